// File: doc/BRIEF.md
# Flyback Drive Protection Sequencer

This block supervises the drive pulses of an offline flyback switcher controller. Analog comparators outside it turn the state of the converter into single-bit flags. These flags report the current limit, overcurrent into the supply clamp, the supply start, stop and reset thresholds, the input-line level and an over-temperature condition. There is also an external latch request. The sequencer turns these flags into one pulse-enable signal, a request for the startup current source, and a 3-bit state code.

Overload and supply overvoltage lead to auto-recovery burst operation. One fault timer validates the overload. The off phase is a whole number of that same timer period, so a fault that persists produces a low-duty burst. A low input line or over-temperature blocks switching until the condition clears, and switching then waits for a fresh supply start. A filtered latch request shuts switching down for good, until the supply collapses below its reset level.

Top module: `flyback_guard`

## Requirements
- R1: After reset the state code is 5 (supply lockout), pulseEn is 0 and restartReq is 1.
- R2: From state 5, the block enters state 0 (run, pulses on) only in the cycle after vccStart goes from 0 to 1. While vccStart stays low, or stays high without a new rising edge, the block remains in state 5.
- R3: In state 0, a high peakLimit moves the block to state 1 (fault wait), and pulses stay enabled. If peakLimit drops before the timer expires, the block returns to state 0, and the timer starts again from zero at the next fault.
- R4: If peakLimit stays high for TICK_DIV*FAULT_TICKS cycles in state 1, the block moves to state 2 (off burst) and pulses stop.
- R5: State 2 lasts exactly OFF_PERIODS*TICK_DIV*FAULT_TICKS cycles, and the block then returns to state 0. If the fault persists, this yields repeated burst cycles.
- R6: If clampOver is high for OVP_FILT consecutive cycles in state 0 or 1, the block moves at once to state 2 for the full off phase. A shorter high pulse has no effect.
- R7: When vccAboveMin is low, the block goes to state 5 in the next cycle from any state other than 4. This applies even while the fault timer runs.
- R8: When brownOk is low or thermHot is high, the block goes to state 3 (blocked) with pulses off. Once both conditions clear, it moves to state 5 and needs a new start crossing.
- R9: If latchReq is high for LATCH_FILT consecutive cycles, the block moves to state 4 (latched). A shorter pulse has no effect. In state 4 only a low vccAboveReset (which leads to state 5) ends the latch, and brown-out or undervoltage have no effect.
- R10: pulseEn is 1 exactly in states 0 and 1. restartReq is 1 exactly in states 2, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| peakLimit | input | 1 | Current setpoint at its maximum |
| clampOver | input | 1 | Overcurrent into the supply clamp |
| vccStart | input | 1 | Supply above the start threshold |
| vccAboveMin | input | 1 | Supply above the stop threshold |
| vccAboveReset | input | 1 | Supply above the latch reset level |
| brownOk | input | 1 | Input line high enough |
| latchReq | input | 1 | External permanent shutdown request |
| thermHot | input | 1 | Hysteretic over-temperature flag |
| pulseEn | output | 1 | Drive pulses allowed |
| restartReq | output | 1 | Startup current source requested |
| stateCode | output | 3 | Current state code |

## Verification
The bench builds the block with TICK_DIV=4, FAULT_TICKS=5, OFF_PERIODS=8, LATCH_FILT=6 and OVP_FILT=3. This gives a 20-cycle fault period and a 160-cycle off phase. With these values the exact expiry cycle of the fault timer and the last cycle of the off burst can be sampled on both sides within a few hundred cycles. The same holds for the one-cycle-short and exact-length pulses on both filters, and for a full burst that restarts into a fault that is still present.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_BURST = 3'd2,
    ST_BLOCK = 3'd3,
    ST_LATCH = 3'd4,
    ST_UVLO  = 3'd5
  } guard_state_e;

  typedef struct packed {
    logic clrTimer;
    logic runTimer;
  } timer_strobe_t;
endpackage

// File: rtl/guard_filter.sv
module guard_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic in,
  output logic hit
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             runCnt <= '0;
    else if (!in)          runCnt <= '0;
    else if (runCnt != LAST) runCnt <= runCnt + 1'b1;
  end

  assign hit = in && (runCnt == LAST);

  generate
    if (LEN > 1) begin : g_chk
      // R6 R9: a hit always follows a high input in the previous cycle
      filt_run_chk: assert property (@(posedge clk) disable iff (!rstN)
        hit |-> $past(in));
    end
  endgenerate
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int FAULT_TICKS = 55000,
  parameter int OFF_PERIODS = 8,
  parameter int LATCH_FILT  = 2000,
  parameter int OVP_FILT    = 5000
) (
  input  logic          clk,
  input  logic          rstN,
  input  timer_strobe_t strobe,
  input  logic          latchReq,
  input  logic          clampOver,
  output logic          periodDone,
  output logic          burstDone,
  output logic          latchHit,
  output logic          ovpHit
);
  localparam int PS_W = $clog2(TICK_DIV + 1);
  localparam int FT_W = $clog2(FAULT_TICKS + 1);
  localparam int OP_W = $clog2(OFF_PERIODS + 1);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);
  localparam logic [FT_W-1:0] FT_LAST = FT_W'(FAULT_TICKS - 1);
  localparam logic [OP_W-1:0] OP_LAST = OP_W'(OFF_PERIODS - 1);

  logic [PS_W-1:0] psCnt;
  logic [FT_W-1:0] tickCnt;
  logic [OP_W-1:0] perCnt;
  logic tick;

  assign tick       = strobe.runTimer && (psCnt == PS_LAST);
  assign periodDone = tick && (tickCnt == FT_LAST);
  assign burstDone  = periodDone && (perCnt == OP_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt   <= '0;
      tickCnt <= '0;
      perCnt  <= '0;
    end else if (strobe.clrTimer) begin
      psCnt   <= '0;
      tickCnt <= '0;
      perCnt  <= '0;
    end else if (strobe.runTimer) begin
      psCnt <= tick ? '0 : psCnt + 1'b1;
      if (tick)       tickCnt <= periodDone ? '0 : tickCnt + 1'b1;
      if (periodDone) perCnt  <= burstDone ? '0 : perCnt + 1'b1;
    end
  end

  guard_filter #(.LEN(LATCH_FILT)) u_latchFilt (
    .clk(clk), .rstN(rstN), .in(latchReq), .hit(latchHit));

  guard_filter #(.LEN(OVP_FILT)) u_ovpFilt (
    .clk(clk), .rstN(rstN), .in(clampOver), .hit(ovpHit));
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          peakLimit,
  input  logic          vccStart,
  input  logic          vccAboveMin,
  input  logic          vccAboveReset,
  input  logic          brownOk,
  input  logic          thermHot,
  input  logic          periodDone,
  input  logic          burstDone,
  input  logic          latchHit,
  input  logic          ovpHit,
  output timer_strobe_t strobe,
  output guard_state_e  state,
  output logic          pulseEn,
  output logic          restartReq
);
  guard_state_e nxt;
  logic startQ;
  logic startRise;
  logic inTimed;

  assign startRise = vccStart && !startQ;

  always_comb begin
    nxt = state;
    if (!vccAboveReset)            nxt = ST_UVLO;
    else if (state == ST_LATCH)    nxt = ST_LATCH;
    else if (latchHit)             nxt = ST_LATCH;
    else if (!vccAboveMin)         nxt = ST_UVLO;
    else if (!brownOk || thermHot) nxt = ST_BLOCK;
    else begin
      case (state)
        ST_UVLO:  if (startRise) nxt = ST_RUN;
        ST_BLOCK: nxt = ST_UVLO;
        ST_RUN: begin
          if (ovpHit)         nxt = ST_BURST;
          else if (peakLimit) nxt = ST_WAIT;
        end
        ST_WAIT: begin
          if (ovpHit)          nxt = ST_BURST;
          else if (!peakLimit) nxt = ST_RUN;
          else if (periodDone) nxt = ST_BURST;
        end
        ST_BURST: if (burstDone) nxt = ST_RUN;
        default:  nxt = ST_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_UVLO;
      startQ <= 1'b0;
    end else begin
      state  <= nxt;
      startQ <= vccStart;
    end
  end

  assign inTimed         = (state == ST_WAIT) || (state == ST_BURST);
  assign strobe.runTimer = inTimed;
  assign strobe.clrTimer = !inTimed || (nxt != state);
  assign pulseEn    = (state == ST_RUN) || (state == ST_WAIT);
  assign restartReq = (state == ST_UVLO) || (state == ST_BURST) || (state == ST_BLOCK);

  // R7
  uvlo_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!vccAboveMin && vccAboveReset && state != ST_LATCH && !latchHit) |=> state == ST_UVLO);

  // R2
  run_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UVLO && !vccStart) |=> state != ST_RUN);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH && vccAboveReset) |=> state == ST_LATCH);

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BURST && !burstDone && vccAboveMin && vccAboveReset && brownOk
     && !thermHot && !latchHit) |=> state == ST_BURST);

  // R6
  ovp_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN || state == ST_WAIT) && ovpHit && vccAboveMin && vccAboveReset
     && brownOk && !thermHot && !latchHit) |=> state == ST_BURST);
endmodule

// File: rtl/flyback_guard.sv
module flyback_guard
  import guard_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int FAULT_TICKS = 55000,
  parameter int OFF_PERIODS = 8,
  parameter int LATCH_FILT  = 2000,
  parameter int OVP_FILT    = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       peakLimit,
  input  logic       clampOver,
  input  logic       vccStart,
  input  logic       vccAboveMin,
  input  logic       vccAboveReset,
  input  logic       brownOk,
  input  logic       latchReq,
  input  logic       thermHot,
  output logic       pulseEn,
  output logic       restartReq,
  output logic [2:0] stateCode
);
  timer_strobe_t strobe;
  guard_state_e  state;
  logic periodDone, burstDone, latchHit, ovpHit;

  guard_timer #(
    .TICK_DIV(TICK_DIV), .FAULT_TICKS(FAULT_TICKS), .OFF_PERIODS(OFF_PERIODS),
    .LATCH_FILT(LATCH_FILT), .OVP_FILT(OVP_FILT)
  ) u_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .latchReq(latchReq),
    .clampOver(clampOver), .periodDone(periodDone), .burstDone(burstDone),
    .latchHit(latchHit), .ovpHit(ovpHit));

  guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .peakLimit(peakLimit), .vccStart(vccStart),
    .vccAboveMin(vccAboveMin), .vccAboveReset(vccAboveReset), .brownOk(brownOk),
    .thermHot(thermHot), .periodDone(periodDone), .burstDone(burstDone),
    .latchHit(latchHit), .ovpHit(ovpHit), .strobe(strobe), .state(state),
    .pulseEn(pulseEn), .restartReq(restartReq));

  assign stateCode = state;
endmodule

// File: tb/flyback_guard_bench.sv
module flyback_guard_bench;
  localparam int TD = 4, FT = 5, OP = 8, LF = 6, OF = 3;
  localparam int PER = TD * FT;
  localparam logic [2:0] S_RUN = 3'd0, S_WAIT = 3'd1, S_BURST = 3'd2,
                         S_BLOCK = 3'd3, S_LATCH = 3'd4, S_UVLO = 3'd5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, peakLimit, clampOver, vccStart, vccAboveMin, vccAboveReset;
  logic brownOk, latchReq, thermHot;
  logic pulseEn, restartReq;
  logic [2:0] stateCode;

  flyback_guard #(.TICK_DIV(TD), .FAULT_TICKS(FT), .OFF_PERIODS(OP),
                  .LATCH_FILT(LF), .OVP_FILT(OF)) u_flyback_guard (
    .clk(clk), .rstN(rstN), .peakLimit(peakLimit), .clampOver(clampOver),
    .vccStart(vccStart), .vccAboveMin(vccAboveMin), .vccAboveReset(vccAboveReset),
    .brownOk(brownOk), .latchReq(latchReq), .thermHot(thermHot),
    .pulseEn(pulseEn), .restartReq(restartReq), .stateCode(stateCode));

  typedef struct {
    logic [2:0] code;
    string      tag;
  } exp_t;

  exp_t q[$];
  event sampleEv;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic expectState(input logic [2:0] code, input string tag);
    exp_t e;
    e.code = code;
    e.tag  = tag;
    q.push_back(e);
    ->sampleEv;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items and compares them with the outputs
  always @(sampleEv) begin
    exp_t e;
    logic expEn, expRr;
    while (q.size() > 0) begin
      e = q.pop_front();
      expEn = (e.code == S_RUN) || (e.code == S_WAIT);                          // R10
      expRr = (e.code == S_UVLO) || (e.code == S_BURST) || (e.code == S_BLOCK); // R10
      checks++;
      if (stateCode !== e.code || pulseEn !== expEn || restartReq !== expRr) begin
        fails++;
        $display("FAIL %s: state=%0d pulseEn=%b restartReq=%b expected state=%0d pulseEn=%b restartReq=%b",
                 e.tag, stateCode, pulseEn, restartReq, e.code, expEn, expRr);
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; peakLimit = 0; clampOver = 0; vccStart = 0; vccAboveMin = 1;
    vccAboveReset = 1; brownOk = 1; latchReq = 0; thermHot = 0;
    step(3);
    rstN = 1;
    step(1); expectState(S_UVLO, "R1 reset state");
    step(3); expectState(S_UVLO, "R2 no start crossing");
    vccStart = 1; step(1); expectState(S_RUN, "R2 start crossing");
    vccStart = 0; step(2); expectState(S_RUN, "R2 stays running");

    // R3 timer start and reset
    peakLimit = 1; step(1); expectState(S_WAIT, "R3 fault wait entry");
    step(10); expectState(S_WAIT, "R3 fault wait holds");
    peakLimit = 0; step(1); expectState(S_RUN, "R3 flag drop returns");
    // R4 expiry boundary, timer counted again from zero
    peakLimit = 1; step(1); expectState(S_WAIT, "R3 restart wait");
    step(PER - 1); expectState(S_WAIT, "R4 last wait cycle");
    step(1); expectState(S_BURST, "R4 expiry stops pulses");
    // R5 off-phase length, restart into persisting fault
    step(PER * OP - 1); expectState(S_BURST, "R5 last off cycle");
    step(1); expectState(S_RUN, "R5 restart attempt");
    step(1); expectState(S_WAIT, "R5 fault persists");
    peakLimit = 0; step(1); expectState(S_RUN, "R3 clear");

    // R6 clamp overcurrent filter
    clampOver = 1; step(OF - 1); clampOver = 0;
    step(1); expectState(S_RUN, "R6 short pulse ignored");
    step(1);
    clampOver = 1; step(OF - 1); expectState(S_RUN, "R6 before filter");
    step(1); expectState(S_BURST, "R6 overvoltage off");
    clampOver = 0;
    step(PER * OP - 1); expectState(S_BURST, "R6 full off phase");
    step(1); expectState(S_RUN, "R6 recovery");

    // R7 undervoltage over running timer
    peakLimit = 1; step(1); expectState(S_WAIT, "R7 timer running");
    step(3); vccAboveMin = 0;
    step(1); expectState(S_UVLO, "R7 lockout priority");
    peakLimit = 0; vccAboveMin = 1;
    step(3); expectState(S_UVLO, "R2 wait for crossing");
    vccStart = 1; step(1); expectState(S_RUN, "R2 crossing after lockout");
    vccStart = 0;

    // R8 brown-out and thermal blocking
    brownOk = 0; step(1); expectState(S_BLOCK, "R8 brown-out blocks");
    step(2); expectState(S_BLOCK, "R8 brown-out holds");
    brownOk = 1; step(1); expectState(S_UVLO, "R8 brown-out clears");
    step(2); expectState(S_UVLO, "R8 waits for crossing");
    vccStart = 1; step(1); expectState(S_RUN, "R8 resumes");
    vccStart = 0;
    thermHot = 1; step(1); expectState(S_BLOCK, "R8 thermal blocks");
    thermHot = 0; step(1); expectState(S_UVLO, "R8 thermal clears");
    vccStart = 1; step(1); expectState(S_RUN, "R8 thermal resume");
    vccStart = 0;

    // R9 latch filter and hold
    latchReq = 1; step(LF - 1); latchReq = 0;
    step(1); expectState(S_RUN, "R9 short request ignored");
    latchReq = 1; step(LF - 1); expectState(S_RUN, "R9 before filter");
    step(1); expectState(S_LATCH, "R9 latched");
    latchReq = 0; brownOk = 0;
    step(2); expectState(S_LATCH, "R9 brown-out no effect");
    brownOk = 1; vccAboveMin = 0;
    step(2); expectState(S_LATCH, "R9 undervoltage no effect");
    vccAboveReset = 0; step(1); expectState(S_UVLO, "R9 reset level clears");
    vccAboveReset = 1; vccAboveMin = 1; step(1);
    vccStart = 1; step(1); expectState(S_RUN, "R9 restart after clear");

    step(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule